// File: doc/BRIEF.md
# I2C slave address event detector

This block sits on the receive side of an I2C controller, after the line sampler. It takes one already decoded bit per SCL rising edge, together with single-cycle START and STOP strobes. It assembles the first byte after each START, MSB first, and compares the upper seven bits with a programmed own address. An all-zero byte counts as a broadcast to every device (general call). When the block is addressed, it samples the ninth bit of every byte as the acknowledge level. It then holds SCL low until software releases the bus.

A STOP that ends a transfer the block accepted in the write direction (R/W = 0) is recorded as a slave-receive stop. The address-match, general-call and slave-stop events all set one pending bit. The interrupt output is that pending bit gated by an enable bit. Software reaches four 16-bit registers through a one-cycle write strobe and a combinational read port. The register is picked by `reg_sel`: 0 control, 1 own address, 2 status, 3 pend.

The control state machine has these states:
- IDLE: after reset or STOP.
- ADDR: collecting the address byte.
- ADDR_ACK: waiting for the address acknowledge bit.
- DATA: collecting a data byte.
- DATA_ACK: waiting for the data acknowledge bit.
- STALL: SCL held.
- SKIP: not addressed, waiting for the next START.

Its transitions, from highest to lowest priority:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- In ADDR, the eighth bit goes to ADDR_ACK on a match or a general call, and to SKIP otherwise.
- In DATA, the eighth bit goes to DATA_ACK.
- From ADDR_ACK or DATA_ACK, the ninth bit goes to STALL.
- In STALL, a release write goes to DATA.

Top module: `i2c_addr_event`

## Requirements
- R1: A write to register 1 stores bits [7:1] as the own address. Bit 0 of register 1 always reads 0, so writing 0xA5 reads back 0xA4.
- R2: After START, once the eighth bit is taken, the outputs change in the next cycle if the byte is non-zero and its bits [7:1] equal the own address: status bit 10 (`addr_hit`) sets and pend bit 0 sets. The R/W bit (bit 0) can be either value.
- R3: An address byte of 0x00 sets status bit 9 (`gen_call`) and pend bit 0, and never sets bit 10, even when the own address is 0.
- R4: An address byte that is neither 0x00 nor a match sets no flag and no hold. Later bits have no effect until the next START.
- R5: In an addressed transfer, the ninth bit of every byte is stored in status bit 0 (`ack_level`: 0 = ACK, 1 = NACK). `scl_hold` rises in the cycle after that bit.
- R6: `scl_hold` stays high until a write to register 3 with bit 1 set. Bits that arrive while the hold is active are not taken into the byte.
- R7: A STOP during an addressed transfer with R/W = 0 sets status bit 8 (`slave_stop`) and pend bit 0. A STOP after R/W = 1, or after an address the block did not accept, does not.
- R8: Writing 1 to bit 0 of register 3 clears the pending bit, and writing 0 leaves it unchanged. An event in the same cycle as the clear leaves it set. Register 3 reads the pending bit at bit 0 and the hold at bit 1.
- R9: `irq` is high exactly when the pending bit is set and control bit 5 is set.
- R10: START clears status bits 10 and 9. Writing 1 to status bit 10, 9 or 8 clears that bit, unless the event that sets it lands in the same cycle.
- R11: After reset, every flag, the pending bit, the hold, `irq`, the control register and the own address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | One-cycle strobe: a decoded bit is on bit_data |
| bit_data | input | 1 | Decoded SDA level |
| start_det | input | 1 | START (or repeated START) seen |
| stop_det | input | 1 | STOP seen |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| addr_hit | output | 1 | Own address matched (status bit 10) |
| gen_call | output | 1 | General call seen (status bit 9) |
| slave_stop | output | 1 | Slave receive ended by STOP (status bit 8) |
| ack_level | output | 1 | Last acknowledge level (status bit 0) |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to drive SCL low |

## Verification
Software clears and bus events can land in the same cycle. The bench aims a pend-clear write at the exact cycle of the eighth address bit, and a status-clear write at the same cycle in a second transfer. In both cases the set must win and the flag must read 1 afterwards, while a later clear with no event pending must still work. The same rule applies to a release write against the hold, and a randomized stream of transfers exercises it further alongside the directed cases.

// File: rtl/i2c_sad_pkg.sv
package i2c_sad_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_STALL,
        ST_SKIP
    } sad_state_t;

    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_OWN  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
    localparam logic [SEL_W-1:0] SEL_PEND = 2'd3;

    localparam int BIT_MATCH = 10;
    localparam int BIT_GCALL = 9;
    localparam int BIT_SSTOP = 8;
    localparam int BIT_ACK   = 0;
    localparam int BIT_PEND  = 0;
    localparam int BIT_REL   = 1;
    localparam int BIT_IEN   = 5;

endpackage

// File: rtl/sad_shift.sv
module sad_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_nxt,
    output logic              last_bit
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (shift_en) begin
            sh_q  <= byte_nxt;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        byte_nxt = {sh_q[BYTE_W-2:0], bit_in};
        last_bit = (cnt_q == CNT_W'(BYTE_W - 1));
    end

    // R5: the counter never runs past one full byte before the ack clears it
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BYTE_W));

endmodule

// File: rtl/sad_fsm.sv
module sad_fsm
    import i2c_sad_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              release_req,
    input  logic [BYTE_W-2:0] own_hi,
    input  logic [BYTE_W-1:0] byte_nxt,
    input  logic              last_bit,
    output logic              shift_en,
    output logic              shift_clr,
    output logic              ev_match,
    output logic              ev_gcall,
    output logic              ev_sstop,
    output logic              ack_we,
    output logic              hold_set,
    output sad_state_t        state
);
    sad_state_t st_q, st_d;
    logic       rw_q;
    logic       addressed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rw_q <= 1'b0;
        else if (start_det) rw_q <= 1'b0;
        else if (ev_match)  rw_q <= byte_nxt[0];
        else if (ev_gcall)  rw_q <= 1'b0;
    end

    always_comb begin
        addressed = (st_q == ST_ADDR_ACK) || (st_q == ST_DATA) ||
                    (st_q == ST_DATA_ACK) || (st_q == ST_STALL);
        st_d      = st_q;
        shift_en  = 1'b0;
        shift_clr = 1'b0;
        ev_match  = 1'b0;
        ev_gcall  = 1'b0;
        ev_sstop  = 1'b0;
        ack_we    = 1'b0;
        hold_set  = 1'b0;
        if (start_det) begin
            st_d      = ST_ADDR;
            shift_clr = 1'b1;
        end else if (stop_det) begin
            st_d     = ST_IDLE;
            ev_sstop = addressed && !rw_q;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: begin
                    if (bit_valid) begin
                        shift_en = 1'b1;
                        if (last_bit) begin
                            if (byte_nxt == '0) begin
                                ev_gcall = 1'b1;
                                st_d     = ST_ADDR_ACK;
                            end else if (byte_nxt[BYTE_W-1:1] == own_hi) begin
                                ev_match = 1'b1;
                                st_d     = ST_ADDR_ACK;
                            end else begin
                                st_d = ST_SKIP;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (bit_valid) begin
                        ack_we    = 1'b1;
                        hold_set  = 1'b1;
                        shift_clr = 1'b1;
                        st_d      = ST_STALL;
                    end
                end
                ST_DATA: begin
                    if (bit_valid) begin
                        shift_en = 1'b1;
                        if (last_bit) st_d = ST_DATA_ACK;
                    end
                end
                ST_STALL: begin
                    if (release_req) st_d = ST_DATA;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign state = st_q;

    // R2: every START opens address collection
    p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st_q == ST_ADDR));

    // R4: an ignored address raises nothing until the next START
    p_skip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SKIP) |-> (!ev_match && !ev_gcall && !hold_set && !ev_sstop));

    // R6: bits in the stall state are never shifted
    p_stall_no_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STALL) |-> !shift_en);

endmodule

// File: rtl/sad_regs.sv
module sad_regs
    import i2c_sad_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              start_det,
    input  logic              ev_match,
    input  logic              ev_gcall,
    input  logic              ev_sstop,
    input  logic              ack_we,
    input  logic              ack_bit,
    input  logic              hold_set,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [BYTE_W-2:0] own_hi,
    output logic              match_q,
    output logic              gcall_q,
    output logic              sstop_q,
    output logic              ack_q,
    output logic              hold_q,
    output logic              release_req,
    output logic              irq
);
    logic [REG_W-1:0] ctrl_q;
    logic             pend_q;
    logic             wr_ctrl, wr_own, wr_stat, wr_pend, any_ev;

    always_comb begin
        wr_ctrl     = reg_wr && (reg_sel == SEL_CTRL);
        wr_own      = reg_wr && (reg_sel == SEL_OWN);
        wr_stat     = reg_wr && (reg_sel == SEL_STAT);
        wr_pend     = reg_wr && (reg_sel == SEL_PEND);
        release_req = wr_pend && reg_wdata[BIT_REL];
        any_ev      = ev_match || ev_gcall || ev_sstop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            own_hi <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata;
            if (wr_own)  own_hi <= reg_wdata[BYTE_W-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            gcall_q <= 1'b0;
            sstop_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            if (ev_match)
                match_q <= 1'b1;
            else if (start_det || (wr_stat && reg_wdata[BIT_MATCH]))
                match_q <= 1'b0;
            if (ev_gcall)
                gcall_q <= 1'b1;
            else if (start_det || (wr_stat && reg_wdata[BIT_GCALL]))
                gcall_q <= 1'b0;
            if (ev_sstop)
                sstop_q <= 1'b1;
            else if (wr_stat && reg_wdata[BIT_SSTOP])
                sstop_q <= 1'b0;
            if (ack_we) ack_q <= ack_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (any_ev)
                pend_q <= 1'b1;
            else if (wr_pend && reg_wdata[BIT_PEND])
                pend_q <= 1'b0;
            if (hold_set)
                hold_q <= 1'b1;
            else if (release_req)
                hold_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_OWN:  reg_rdata[BYTE_W-1:0] = {own_hi, 1'b0};
            SEL_STAT: begin
                reg_rdata[BIT_MATCH] = match_q;
                reg_rdata[BIT_GCALL] = gcall_q;
                reg_rdata[BIT_SSTOP] = sstop_q;
                reg_rdata[BIT_ACK]   = ack_q;
            end
            SEL_PEND: begin
                reg_rdata[BIT_PEND] = pend_q;
                reg_rdata[BIT_REL]  = hold_q;
            end
            default: reg_rdata = '0;
        endcase
        irq = pend_q && ctrl_q[BIT_IEN];
    end

    // R8: a clear with no event in the same cycle empties the pending bit
    p_pend_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && reg_wdata[BIT_PEND] && !any_ev) |=> !pend_q);

    // R2: any accepted event leaves the pending bit set
    p_event_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_ev |=> pend_q);

    // R6: the hold only drops on a release write
    p_hold_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !release_req) |=> hold_q);

    // R10: START wipes the address flags
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!match_q && !gcall_q));

endmodule

// File: rtl/i2c_addr_event.sv
module i2c_addr_event
    import i2c_sad_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             addr_hit,
    output logic             gen_call,
    output logic             slave_stop,
    output logic             ack_level,
    output logic             irq,
    output logic             scl_hold
);
    logic [BYTE_W-1:0] byte_nxt;
    logic [BYTE_W-2:0] own_hi;
    logic              last_bit, shift_en, shift_clr;
    logic              ev_match, ev_gcall, ev_sstop, ack_we, hold_set, release_req;
    sad_state_t        state;

    sad_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_clr (shift_clr),
        .shift_en  (shift_en),
        .bit_in    (bit_data),
        .byte_nxt  (byte_nxt),
        .last_bit  (last_bit)
    );

    sad_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .release_req (release_req),
        .own_hi      (own_hi),
        .byte_nxt    (byte_nxt),
        .last_bit    (last_bit),
        .shift_en    (shift_en),
        .shift_clr   (shift_clr),
        .ev_match    (ev_match),
        .ev_gcall    (ev_gcall),
        .ev_sstop    (ev_sstop),
        .ack_we      (ack_we),
        .hold_set    (hold_set),
        .state       (state)
    );

    sad_regs #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .start_det   (start_det),
        .ev_match    (ev_match),
        .ev_gcall    (ev_gcall),
        .ev_sstop    (ev_sstop),
        .ack_we      (ack_we),
        .ack_bit     (bit_data),
        .hold_set    (hold_set),
        .reg_rdata   (reg_rdata),
        .own_hi      (own_hi),
        .match_q     (addr_hit),
        .gcall_q     (gen_call),
        .sstop_q     (slave_stop),
        .ack_q       (ack_level),
        .hold_q      (scl_hold),
        .release_req (release_req),
        .irq         (irq)
    );

    // R6: the stall state always has SCL held
    p_stall_holds_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STALL) |-> scl_hold);

    // R3: a general call never reports an address match
    p_gcall_excludes_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_hit && gen_call));

endmodule

// File: tb/i2c_addr_event_test.sv
module i2c_addr_event_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0, bit_data = 1'b0;
    logic        start_det = 1'b0, stop_det = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        addr_hit, gen_call, slave_stop, ack_level, irq, scl_hold;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m_own = 8'h00;
    logic m_match = 0, m_gcall = 0, m_sstop = 0, m_pend = 0, m_hold = 0, m_ack = 0, m_ien = 0;

    always #10 clk = ~clk;

    i2c_addr_event uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .start_det(start_det), .stop_det(stop_det), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .addr_hit(addr_hit), .gen_call(gen_call), .slave_stop(slave_stop),
        .ack_level(ack_level), .irq(irq), .scl_hold(scl_hold)
    );

    function automatic logic is_hit(input logic [7:0] b);
        return (b != 8'h00) && (b[7:1] == m_own[7:1]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic chk_all(input string req);
        logic [15:0] v;
        chk({req, " hit"}, addr_hit, m_match);
        chk({req, " gcall"}, gen_call, m_gcall);
        chk({req, " sstop"}, slave_stop, m_sstop);
        chk({req, " ack"}, ack_level, m_ack);
        chk({req, " hold"}, scl_hold, m_hold);
        chk({req, " R9 irq"}, irq, m_pend & m_ien);
        rd(2'd3, v);
        chk({req, " R8 pendreg"}, v, {14'd0, m_hold, m_pend});
    endtask

    task automatic put_bit(input logic b);
        bit_valid = 1'b1; bit_data = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
    endtask

    task automatic do_start();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        m_match = 0; m_gcall = 0;
    endtask

    task automatic do_stop(input logic wr_dir_addr);
        stop_det = 1'b1;
        @(negedge clk);
        stop_det = 1'b0;
        if (wr_dir_addr) begin m_sstop = 1; m_pend = 1; end
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cleanup();
        wr(2'd3, 16'h0003); m_pend = 0; m_hold = 0;
        wr(2'd2, 16'h0700); m_match = 0; m_gcall = 0; m_sstop = 0;
        chk_all("R8_R10 cleanup");
    endtask

    task automatic addr_phase(input logic [7:0] ab, output logic acc);
        put_byte(ab);
        acc = 1'b0;
        if (ab == 8'h00) begin m_gcall = 1; m_pend = 1; acc = 1'b1; end
        else if (is_hit(ab)) begin m_match = 1; m_pend = 1; acc = 1'b1; end
        chk_all("R2_R3_R4 address");
    endtask

    task automatic rnd_txn();
        logic [7:0] ab;
        logic acc, a;
        int kind, nd;
        m_ien = 1'($urandom % 2);
        wr(2'd0, {10'd0, m_ien, 5'd0});
        do_start();
        kind = $urandom % 4;
        if (kind == 0)      ab = {m_own[7:1], 1'($urandom % 2)};
        else if (kind == 1) ab = 8'h00;
        else                ab = 8'($urandom);
        addr_phase(ab, acc);
        if (acc) begin
            a = 1'($urandom % 2);
            put_bit(a); m_ack = a; m_hold = 1;
            chk_all("R5 addr ack");
            nd = $urandom % 3;
            for (int k = 0; k < nd; k++) begin
                wr(2'd3, 16'h0002); m_hold = 0;
                chk_all("R6 release");
                put_byte(8'($urandom));
                a = 1'($urandom % 2);
                put_bit(a); m_ack = a; m_hold = 1;
                chk_all("R5 data ack");
            end
        end else begin
            put_byte(8'($urandom));
            chk_all("R4 ignored bits");
        end
        if (($urandom % 4) != 0) begin
            do_stop(acc && (ab == 8'h00 || ab[0] == 1'b0));
            chk_all("R7 stop");
        end
        cleanup();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic acc;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk_all("R11 reset");
        rd(2'd0, v); chk("R11 ctrl", v, 16'h0);
        rd(2'd1, v); chk("R11 own", v, 16'h0);

        // R3 own address zero, broadcast byte
        do_start();
        addr_phase(8'h00, acc);
        chk("R3 gcall only", {gen_call, addr_hit}, 2'b10);
        cleanup();

        // R1 own address readback
        wr(2'd1, 16'h00A5); m_own = 8'hA4;
        rd(2'd1, v); chk("R1 own bit0", v, 16'h00A4);

        // R9 gate: pending with enable off, then on
        do_start();
        addr_phase(8'hA4, acc);
        chk("R9 irq off", irq, 1'b0);
        wr(2'd0, 16'h0020); m_ien = 1;
        chk("R9 irq on", irq, 1'b1);
        // R5 + R6: junk bits during hold are not shifted
        put_bit(1'b0); m_ack = 0; m_hold = 1;
        chk_all("R5 first ack");
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
        chk_all("R6 held junk");
        wr(2'd3, 16'h0002); m_hold = 0;
        put_byte(8'h3C);
        chk("R6 no early hold", scl_hold, 1'b0);
        put_bit(1'b1); m_ack = 1; m_hold = 1;
        chk_all("R6 ack after full byte");
        do_stop(1'b1);
        chk_all("R7 write stop");
        // R8 writing 0 does not clear
        wr(2'd3, 16'h0000);
        chk_all("R8 write zero");
        cleanup();

        // R8 collision: clear lands on the eighth address bit
        do_start();
        for (int i = 7; i >= 1; i--) put_bit(m_own[i]);
        bit_valid = 1'b1; bit_data = 1'b1;
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 16'h0001;
        @(negedge clk);
        bit_valid = 1'b0; reg_wr = 1'b0;
        m_match = 1; m_pend = 1;
        chk_all("R8 set beats clear");
        // R7 read direction: no slave stop
        put_bit(1'b0); m_ack = 0; m_hold = 1;
        do_stop(1'b0);
        chk_all("R7 read stop");
        cleanup();

        // R10 collision: status clear lands on the eighth address bit
        do_start();
        for (int i = 7; i >= 1; i--) put_bit(m_own[i]);
        bit_valid = 1'b1; bit_data = 1'b0;
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h0400;
        @(negedge clk);
        bit_valid = 1'b0; reg_wr = 1'b0;
        m_match = 1; m_pend = 1;
        chk_all("R10 set beats clear");
        wr(2'd2, 16'h0400); m_match = 0;
        chk_all("R10 sw clear");
        // R10 start clears match
        put_bit(1'b0); m_ack = 0; m_hold = 1;
        wr(2'd3, 16'h0003); m_pend = 0; m_hold = 0;
        do_start();
        addr_phase(m_own, acc);
        do_start();
        chk_all("R10 start clears");
        put_byte(8'h5A);
        chk_all("R4 nonmatch");
        cleanup();

        // randomized transfers
        for (int t = 0; t < 80; t++) begin
            if ((t % 8) == 0) begin
                m_own = 8'((($urandom % 127) + 1) << 1);
                wr(2'd1, {8'h00, m_own});
            end
            rnd_txn();
        end

        summary();
        $finish;
    end
endmodule